// File: doc/BRIEF.md
# ADC Result Register and Status Logic

This block stores conversion results from two converters: a primary one and an auxiliary one. It keeps a status word that software reads back to find out why an interrupt happened. A result arrives as a 24-bit sample with a one-cycle valid strobe and two range flags. The block accepts the sample only when software has consumed the previous one. While the chip is powered down it always accepts the sample. An out-of-range sample is replaced by the matching full-scale code, and the error is recorded in the status word.

Software reaches the block through a small register port with a read strobe, a write strobe and a 3-bit address. Reading a result register can release the ready flags. Which read releases which flags depends on whether the primary converter is enabled. Writing the mode register clears the calibration flag. A mask register selects which status bits drive the single interrupt line.

Top module: `adc_result_status`

## Requirements
- R1: A read of the primary data register (address 1) clears both result-ready flags: status bit 0 (primary) and status bit 1 (auxiliary).
- R2: A read of the auxiliary data register (address 2) clears both ready flags when `pri_en` is low. It leaves both flags unchanged when `pri_en` is high.
- R3: While a channel's ready flag is set and `pwr_down` is low, a new result on that channel is discarded. The data register, the ready flag and the error bit all keep their values.
- R4: While `pwr_down` is high, every valid result is written into its data register and sets the ready flag, whatever state the ready flag is in.
- R5: An accepted result flagged overrange is stored as 0x7FFFFF. One flagged underrange is stored as 0x800000. When both flags are set, overrange wins. The conversion-error bit of that channel is set: status bit 12 for primary, bit 13 for auxiliary.
- R6: An accepted in-range result is stored unchanged and clears that channel's conversion-error bit.
- R7: Status bit 15 is set when `cal_done` pulses and cleared by a write to the mode register (address 3). If both happen in the same cycle, the set wins.
- R8: `irq` is high exactly when some status bit is set and its bit in the mask register (address 4) is also set.
- R9: After reset the status word, both data registers, the mode and mask registers and `irq` are all zero. Status bits 11 to 7 always read as zero.
- R10: Address 0 reads the status word. Addresses 1 and 2 read the data registers. Addresses 3 and 4 read back the mode and mask registers, zero-extended. `reg_rdata` holds the value one cycle after the read strobe.
- R11: An accepted result sets its ready flag one cycle after its valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_vld | input | 1 | Primary result strobe |
| pri_data | input | 24 | Primary result, two's complement |
| pri_ovr | input | 1 | Primary result above range |
| pri_und | input | 1 | Primary result below range |
| aux_vld | input | 1 | Auxiliary result strobe |
| aux_data | input | 24 | Auxiliary result, two's complement |
| aux_ovr | input | 1 | Auxiliary result above range |
| aux_und | input | 1 | Auxiliary result below range |
| cal_done | input | 1 | Calibration cycle finished |
| pri_en | input | 1 | Primary converter enabled |
| pwr_down | input | 1 | Processor powered down |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 24 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Every effect of a result strobe, a read or a write takes exactly one clock edge. A result driven before edge k shows in the data register and the status flags after edge k. A read issued before edge k returns data after edge k, and in the same edge it clears the ready flags. `irq` is combinational from registered state, so it changes in the same cycle as the status bits. The bench drives inputs just after a falling edge and samples one falling edge later, so each check falls on the first cycle its result is due.

// File: rtl/adcrs_pkg.sv
package adcrs_pkg;
    localparam int RES_W  = 24;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_PDAT = 3'd1,
        A_ADAT = 3'd2,
        A_MODE = 3'd3,
        A_MASK = 3'd4
    } reg_addr_e;

    localparam int ST_PRDY = 0;
    localparam int ST_ARDY = 1;
    localparam int ST_PERR = 12;
    localparam int ST_AERR = 13;
    localparam int ST_CAL  = 15;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             ovr;
        logic             und;
    } res_t;

    localparam logic [RES_W-1:0] FS_POS = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] FS_NEG = {1'b1, {(RES_W-1){1'b0}}};

    function automatic logic [RES_W-1:0] clamp_res(input res_t r);
        if (r.ovr)      return FS_POS;
        else if (r.und) return FS_NEG;
        else            return r.data;
    endfunction
endpackage

// File: rtl/adcrs_chan.sv
module adcrs_chan
    import adcrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  res_t             in_res,
    input  logic             pwr_down,
    input  logic             clr_rdy,
    output logic [RES_W-1:0] dat_q,
    output logic             rdy_q,
    output logic             err_q
);
    logic take;
    // accept when previous result consumed, or unconditionally in power-down
    assign take = in_vld && (!rdy_q || pwr_down);

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
            rdy_q <= 1'b0;
            err_q <= 1'b0;
        end else if (take) begin
            dat_q <= clamp_res(in_res);
            err_q <= in_res.ovr | in_res.und;
            rdy_q <= 1'b1;
        end else if (clr_rdy) begin
            rdy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adcrs_ctrl.sv
module adcrs_ctrl
    import adcrs_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              cal_done,
    output logic [REG_W-1:0]  mode_q,
    output logic [REG_W-1:0]  mask_q,
    output logic              cal_q
);
    logic wr_mode, wr_mask;
    assign wr_mode = wr_en && (reg_addr_e'(addr) == A_MODE);
    assign wr_mask = wr_en && (reg_addr_e'(addr) == A_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
            cal_q  <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_mask) mask_q <= wdata;
            // completion event outranks the clearing write
            if (cal_done)     cal_q <= 1'b1;
            else if (wr_mode) cal_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_result_status.sv
module adc_result_status
    import adcrs_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_vld,
    input  logic [RES_W-1:0]  pri_data,
    input  logic              pri_ovr,
    input  logic              pri_und,
    input  logic              aux_vld,
    input  logic [RES_W-1:0]  aux_data,
    input  logic              aux_ovr,
    input  logic              aux_und,
    input  logic              cal_done,
    input  logic              pri_en,
    input  logic              pwr_down,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [RES_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int NCH = 2;
    localparam int PAD = RES_W - REG_W;

    res_t             res_in [NCH];
    logic [NCH-1:0]   vld_in;
    logic [NCH-1:0]   rdy;
    logic [NCH-1:0]   err;
    logic [RES_W-1:0] dat [NCH];
    logic             clr_all;
    logic             rd_pri, rd_aux;
    logic [REG_W-1:0] mode_q, mask_q, status_w;
    logic             cal_q;
    logic [RES_W-1:0] pri_q;

    assign res_in[0] = '{data: pri_data, ovr: pri_ovr, und: pri_und};
    assign res_in[1] = '{data: aux_data, ovr: aux_ovr, und: aux_und};
    assign vld_in    = {aux_vld, pri_vld};

    assign rd_pri  = reg_rd && (reg_addr_e'(reg_addr) == A_PDAT);
    assign rd_aux  = reg_rd && (reg_addr_e'(reg_addr) == A_ADAT);
    // primary read always releases both; auxiliary read only without primary
    assign clr_all = rd_pri || (rd_aux && !pri_en);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            adcrs_chan u_chan (
                .clk      (clk),
                .rst      (rst),
                .in_vld   (vld_in[g]),
                .in_res   (res_in[g]),
                .pwr_down (pwr_down),
                .clr_rdy  (clr_all),
                .dat_q    (dat[g]),
                .rdy_q    (rdy[g]),
                .err_q    (err[g])
            );
        end
    endgenerate

    assign pri_q = dat[0];

    adcrs_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cal_done (cal_done),
        .mode_q   (mode_q),
        .mask_q   (mask_q),
        .cal_q    (cal_q)
    );

    always_comb begin
        status_w          = '0;
        status_w[ST_PRDY] = rdy[0];
        status_w[ST_ARDY] = rdy[1];
        status_w[ST_PERR] = err[0];
        status_w[ST_AERR] = err[1];
        status_w[ST_CAL]  = cal_q;
    end

    assign irq = |(status_w & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr_e'(reg_addr))
                A_STAT:  reg_rdata <= {{PAD{1'b0}}, status_w};
                A_PDAT:  reg_rdata <= dat[0];
                A_ADAT:  reg_rdata <= dat[1];
                A_MODE:  reg_rdata <= {{PAD{1'b0}}, mode_q};
                A_MASK:  reg_rdata <= {{PAD{1'b0}}, mask_q};
                default: reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/adcrs_checker.sv
module adcrs_checker
    import adcrs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pri_vld,
    input logic [RES_W-1:0]  pri_data,
    input logic              pri_ovr,
    input logic              pri_und,
    input logic              aux_vld,
    input logic              pri_en,
    input logic              pwr_down,
    input logic              cal_done,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              irq,
    input logic [15:0]       status,
    input logic [15:0]       mask,
    input logic [RES_W-1:0]  p_dat
);
    AST_PRI_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd1 && !pri_vld && !aux_vld) |=> (status[1:0] == 2'b00)); // R1

    AST_AUX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd2 && !pri_en && !pri_vld && !aux_vld) |=> (status[1:0] == 2'b00)); // R2

    AST_HOLD_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !pwr_down) |=> $stable(p_dat)); // R3

    AST_PDN_TAKES_NEWEST: assert property (@(posedge clk) disable iff (rst)
        (pri_vld && pwr_down && !pri_ovr && !pri_und) |=> (p_dat == $past(pri_data) && status[0])); // R4

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pri_vld && pri_ovr && (!status[0] || pwr_down)) |=> (p_dat == 24'h7FFFFF && status[12])); // R5

    AST_CAL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3 && !cal_done) |=> !status[15]); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == 16'h0000) |-> !irq); // R8

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_wr) |-> (status[11:7] == 5'b0)); // R9
endmodule

bind adc_result_status adcrs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pri_vld  (pri_vld),
    .pri_data (pri_data),
    .pri_ovr  (pri_ovr),
    .pri_und  (pri_und),
    .aux_vld  (aux_vld),
    .pri_en   (pri_en),
    .pwr_down (pwr_down),
    .cal_done (cal_done),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .irq      (irq),
    .status   (status_w),
    .mask     (mask_q),
    .p_dat    (pri_q)
);

// File: tb/test_adc_result_status.sv
`timescale 1ns/1ps
module test_adc_result_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pri_vld = 0, pri_ovr = 0, pri_und = 0;
    logic [23:0] pri_data = '0;
    logic        aux_vld = 0, aux_ovr = 0, aux_und = 0;
    logic [23:0] aux_data = '0;
    logic        cal_done = 0, pri_en = 1, pwr_down = 0;
    logic [2:0]  reg_addr = '0;
    logic        reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    adc_result_status i_adc_result_status (
        .clk(clk), .rst(rst),
        .pri_vld(pri_vld), .pri_data(pri_data), .pri_ovr(pri_ovr), .pri_und(pri_und),
        .aux_vld(aux_vld), .aux_data(aux_data), .aux_ovr(aux_ovr), .aux_und(aux_und),
        .cal_done(cal_done), .pri_en(pri_en), .pwr_down(pwr_down),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {input data, ovr, und, expected stored value}
    localparam logic [49:0] VEC [6] = '{
        {24'h123456, 1'b0, 1'b0, 24'h123456},
        {24'h000100, 1'b1, 1'b0, 24'h7FFFFF},
        {24'h654321, 1'b0, 1'b0, 24'h654321},
        {24'h000001, 1'b0, 1'b1, 24'h800000},
        {24'h800000, 1'b1, 1'b1, 24'h7FFFFF},
        {24'hFFFFFE, 1'b0, 1'b0, 24'hFFFFFE}
    };

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic push_pri(input logic [23:0] d, input logic o, input logic u);
        pri_vld = 1; pri_data = d; pri_ovr = o; pri_und = u;
        @(negedge clk);
        pri_vld = 0; pri_ovr = 0; pri_und = 0;
    endtask

    task automatic push_aux(input logic [23:0] d, input logic o, input logic u);
        aux_vld = 1; aux_data = d; aux_ovr = o; aux_und = u;
        @(negedge clk);
        aux_vld = 0; aux_ovr = 0; aux_und = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] v);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R9 reset state
        rd(3'd0, v); chk("R9 status after reset", v, 24'h0);
        rd(3'd1, v); chk("R9 primary data after reset", v, 24'h0);
        chk("R9 irq after reset", {23'b0, irq}, 24'h0);

        // table: R5, R6, R11, R1
        for (int i = 0; i < 6; i++) begin
            logic [23:0] d, e;
            logic o, u;
            {d, o, u, e} = VEC[i];
            push_pri(d, o, u);
            rd(3'd0, v);
            chk("R11 primary ready set", {23'b0, v[0]}, 24'h1);
            chk("R5 R6 primary error bit", {23'b0, v[12]}, {23'b0, o | u});
            rd(3'd1, v); chk("R5 R6 stored primary value", v, e);
            rd(3'd0, v); chk("R1 ready cleared by primary read", {23'b0, v[0]}, 24'h0);
        end

        // R3 blocked update
        push_pri(24'h0000AA, 0, 0);
        push_pri(24'h0000BB, 1, 0);
        rd(3'd0, v); chk("R3 error bit kept on discarded result", {23'b0, v[12]}, 24'h0);
        rd(3'd1, v); chk("R3 discarded result", v, 24'h0000AA);

        // R2 asymmetric clear
        pri_en = 1;
        push_aux(24'h111111, 0, 0);
        rd(3'd2, v); chk("R10 auxiliary data read", v, 24'h111111);
        rd(3'd0, v); chk("R2 aux read keeps ready with primary enabled", {23'b0, v[1]}, 24'h1);
        push_aux(24'h222222, 0, 0);
        rd(3'd2, v); chk("R3 auxiliary update blocked", v, 24'h111111);
        rd(3'd1, v);
        rd(3'd0, v); chk("R1 primary read clears aux ready", {22'b0, v[1:0]}, 24'h0);
        pri_en = 0;
        push_pri(24'h000033, 0, 0);
        push_aux(24'h000044, 0, 1);
        rd(3'd0, v); chk("R5 aux underrange error bit", {23'b0, v[13]}, 24'h1);
        rd(3'd2, v); chk("R5 aux clamp to negative full scale", v, 24'h800000);
        rd(3'd0, v); chk("R2 aux read clears both with primary disabled", {22'b0, v[1:0]}, 24'h0);
        pri_en = 1;

        // R4 power-down
        push_pri(24'h000055, 0, 0);
        pwr_down = 1;
        push_pri(24'h000066, 0, 0);
        pwr_down = 0;
        rd(3'd1, v); chk("R4 newest result taken in power-down", v, 24'h000066);

        // R7 calibration flag
        cal_done = 1; @(negedge clk); cal_done = 0;
        rd(3'd0, v); chk("R7 calibration flag set", {23'b0, v[15]}, 24'h1);
        wr(3'd3, 16'h00A5);
        rd(3'd0, v); chk("R7 calibration flag cleared by mode write", {23'b0, v[15]}, 24'h0);
        rd(3'd3, v); chk("R10 mode readback", v, 24'h0000A5);
        cal_done = 1; reg_wr = 1; reg_addr = 3'd3; reg_wdata = 16'h0001;
        @(negedge clk); cal_done = 0; reg_wr = 0;
        rd(3'd0, v); chk("R7 set wins over same-cycle mode write", {23'b0, v[15]}, 24'h1);
        rd(3'd0, v); chk("R9 reserved bits read zero", {19'b0, v[11:7]}, 24'h0);

        // R8 interrupt masking
        push_pri(24'h000077, 0, 0);
        chk("R8 irq low with mask clear", {23'b0, irq}, 24'h0);
        wr(3'd4, 16'h0001);
        chk("R8 irq from unmasked ready", {23'b0, irq}, 24'h1);
        rd(3'd4, v); chk("R10 mask readback", v, 24'h000001);
        rd(3'd1, v);
        chk("R8 irq drops after ready clears", {23'b0, irq}, 24'h0);
        wr(3'd4, 16'h1000);
        push_pri(24'h000001, 1, 0);
        chk("R8 irq from unmasked error bit", {23'b0, irq}, 24'h1);
        rd(3'd1, v);
        push_pri(24'h000002, 0, 0);
        chk("R6 irq drops when error clears", {23'b0, irq}, 24'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule